// File: doc/BRIEF.md
# Per-Area External Bus Interface

This block turns single requests from one internal master into cycles on an external memory bus. The 24-bit request address splits into eight equal areas of 2 Mbytes, and the three top address bits name the area. Each area has its own data width (8 or 16 bits), its own basic timing (2 or 3 bus states) and its own wait count (0 to 3). While a cycle runs, the block drives the active-low chip select of the selected area. Read and write strobes follow the timing of that area.

The master raises `req` and holds its address, write data, byte enables and direction until `ready` pulses for one cycle. On a read, `rdata` is valid in that same cycle. A separate configuration port loads the per-area settings and the two idle-cycle enables. The settings are taken at the start of each request, so a change only affects later requests. A 16-bit request to an 8-bit area becomes two byte cycles. An idle bus cycle can be placed before a read that changes area after a read. One can also be placed before any write that follows a read.

Top module: `ext_bus_if`

## Requirements
- R1: The area is `req_addr[23:21]`. During the bus states of a cycle, exactly the chip select `ext_cs_n[area]` is low. At all other times every chip select is high.
- R2: A write on the configuration port with `cfg_sel` 0..7 loads that area's setting from `cfg_wdata` (bits [3:2] wait count, bit 1 three-state, bit 0 wide). With `cfg_sel` = 8 it loads the idle enables (bit 0 read-to-read area change, bit 1 write after read). Other `cfg_sel` values change nothing. After reset every area is 8-bit, three-state with 3 waits, and both idle enables are set.
- R3: A cycle has N bus states: N = 2 in two-state mode and N = 3 + wait count in three-state mode. `ready` is a single-cycle pulse. Counting from the clock edge that accepts `req`, it is seen after 1 + idle + halves×N edges (halves is 2 for a split, else 1).
- R4: Wait states are added only in three-state mode. A two-state area ignores its wait count.
- R5: `ext_rd_n` is low in every bus state of a read. Each write strobe that is in use is low in every bus state of a write except the first.
- R6: On a 16-bit area, `req_be[1]` selects data bits [15:8] at the even address and `req_be[0]` selects bits [7:0] at the odd address. `ext_wrh_n` and `ext_wrl_n` follow the enabled lanes. `ext_addr[0]` is 0 when `req_be[1]` is set, else 1.
- R7: On an 8-bit area only data bits [15:8] carry data and `ext_wrl_n` stays high. A single-byte request uses the even address for `req_be` = 10 and the odd address for 01. Read data returns in the lane named by the byte enable.
- R8: `req_be` = 11 on an 8-bit area runs two back-to-back byte cycles: first the even address with the upper byte, then the odd address with the lower byte. `ready` comes only after the second cycle.
- R9: If the previous external cycle was a read and the read-change enable is set, a read to a different area is preceded by one idle cycle. In that cycle all chip selects and strobes are high.
- R10: If the previous external cycle was a read and the write-after-read enable is set, a write is preceded by one such idle cycle.
- R11: No idle cycle is added when the matching enable is clear, for a read that follows a read of the same area, or after a write.
- R12: A configuration write made while a cycle runs does not change that cycle. The next request uses the new setting.
- R13: After reset all chip selects and strobes are high, `ext_doe` and `ready` are low. Read-data bytes not enabled by `req_be` return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target: area 0..7, 8 = idle enables |
| cfg_wdata | input | 4 | Configuration value |
| req | input | 1 | Request, held until ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data, [15:8] is the even byte |
| req_be | input | 2 | Byte enables, [1] even byte, [0] odd byte |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ready |
| ext_addr | output | 24 | External address |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | External data output enable |
| ext_din | input | 16 | External read data |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wrh_n | output | 1 | Upper-lane write strobe, active low |
| ext_wrl_n | output | 1 | Lower-lane write strobe, active low |
| ext_cs_n | output | 8 | Per-area chip selects, active low |

## Verification
The assertions check the following on every cycle:
- At most one chip select is low, and chip-select activity matches strobe and drive activity.
- The idle cycle drives nothing.
- No write strobe is low in the first bus state.
- The lower write strobe stays quiet on narrow areas.
- Wait states occur only in three-state mode.
- A split request signals completion only after its second half.
- The captured settings stay constant within a cycle.

Only the bench scenarios can show the following:
- The full cycle length for each width, timing and wait combination.
- Byte-lane and address placement of data, and read-data assembly.
- Whether an idle cycle is or is not inserted, given the history of previous cycles and the enables.
- That a setting changed in mid-cycle is applied only to the next request.

// File: rtl/ebi_pkg.sv
package ebi_pkg;

    localparam int WAIT_W = 2;
    localparam int CFG_W  = WAIT_W + 2;

    // Per-area setting, laid out as written on the configuration port
    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              three;
        logic              wide;
    } area_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3
    } bus_st_e;

endpackage

// File: rtl/ebi_cfg_bank.sv
module ebi_cfg_bank
    import ebi_pkg::*;
#(
    parameter int N_AREAS = 8,
    parameter int SEL_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output area_cfg_t        area_cfg_o [N_AREAS],
    output logic             idle_rr_en_o,
    output logic             idle_rw_en_o
);

    localparam logic [SEL_W-1:0] IDLE_SEL = SEL_W'(N_AREAS);
    localparam area_cfg_t CFG_RESET = '{waits: '1, three: 1'b1, wide: 1'b0};

    logic [1:0] idle_en_d, idle_en_q;

    generate
        for (genvar g = 0; g < N_AREAS; g++) begin : g_area
            area_cfg_t cfg_d, cfg_q;

            always_comb begin
                cfg_d = cfg_q;
                if (cfg_we && cfg_sel == SEL_W'(g)) begin
                    cfg_d = area_cfg_t'(cfg_wdata);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cfg_q <= CFG_RESET;
                else        cfg_q <= cfg_d;
            end

            assign area_cfg_o[g] = cfg_q;
        end
    endgenerate

    always_comb begin
        idle_en_d = idle_en_q;
        if (cfg_we && cfg_sel == IDLE_SEL) begin
            idle_en_d = cfg_wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_en_q <= 2'b11;
        else        idle_en_q <= idle_en_d;
    end

    assign idle_rr_en_o = idle_en_q[0];
    assign idle_rw_en_o = idle_en_q[1];

endmodule

// File: rtl/ebi_area_decode.sv
module ebi_area_decode #(
    parameter  int N_AREAS = 8,
    localparam int AREA_W  = $clog2(N_AREAS)
) (
    input  logic [AREA_W-1:0]  area_i,
    input  logic               active_i,
    output logic [N_AREAS-1:0] cs_n_o
);

    generate
        for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
            assign cs_n_o[g] = !(active_i && area_i == AREA_W'(g));
        end
    endgenerate

endmodule

// File: rtl/ebi_cycle_seq.sv
module ebi_cycle_seq
    import ebi_pkg::*;
#(
    parameter  int ADDR_W  = 24,
    parameter  int DATA_W  = 16,
    parameter  int N_AREAS = 8,
    localparam int AREA_W  = $clog2(N_AREAS),
    localparam int BYTE_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [1:0]        be_i,
    input  logic [AREA_W-1:0] req_area_i,
    input  area_cfg_t         area_cfg_i [N_AREAS],
    input  logic              idle_rr_en_i,
    input  logic              idle_rw_en_i,
    input  logic [DATA_W-1:0] ext_din_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] ext_addr_o,
    output logic [DATA_W-1:0] ext_dout_o,
    output logic              ext_doe_o,
    output logic              rd_n_o,
    output logic              wrh_n_o,
    output logic              wrl_n_o,
    output logic              active_o,
    output logic [AREA_W-1:0] area_o
);

    typedef struct packed {
        bus_st_e           st;
        logic [AREA_W-1:0] area;
        area_cfg_t         cfg;
        logic              we;
        logic [ADDR_W-1:1] waddr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        be;
        logic              split;
        logic              half;
        logic [WAIT_W-1:0] wcnt;
        logic              prev_valid;
        logic              prev_read;
        logic [AREA_W-1:0] prev_area;
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;

    logic unused_addr_lsb;
    assign unused_addr_lsb = addr_i[0];

    // Which byte the current (narrow) bus cycle carries
    logic cur_lo;
    logic active;
    logic wr_phase;
    logic need_gap;
    logic last_state;
    logic [BYTE_W-1:0] din_hi, din_lo;

    assign cur_lo = s_q.split ? s_q.half : !s_q.be[1];
    assign active = (s_q.st == ST_T1) || (s_q.st == ST_T2) ||
                    (s_q.st == ST_TW) || (s_q.st == ST_T3);
    assign wr_phase = active && s_q.we && (s_q.st != ST_T1);
    assign din_hi = ext_din_i[DATA_W-1:BYTE_W];
    assign din_lo = ext_din_i[BYTE_W-1:0];

    assign need_gap = s_q.prev_valid && s_q.prev_read &&
                      ((!we_i && idle_rr_en_i && (req_area_i != s_q.prev_area)) ||
                       (we_i && idle_rw_en_i));

    always_comb begin
        s_d        = s_q;
        s_d.ready  = 1'b0;
        last_state = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (req_i && !s_q.ready) begin
                    s_d.area  = req_area_i;
                    s_d.cfg   = area_cfg_i[req_area_i];
                    s_d.we    = we_i;
                    s_d.waddr = addr_i[ADDR_W-1:1];
                    s_d.wdata = wdata_i;
                    s_d.be    = be_i;
                    s_d.split = !area_cfg_i[req_area_i].wide && (be_i == 2'b11);
                    s_d.half  = 1'b0;
                    s_d.rdata = '0;
                    s_d.st    = need_gap ? ST_GAP : ST_T1;
                end
            end
            ST_GAP: s_d.st = ST_T1;
            ST_T1:  s_d.st = ST_T2;
            ST_T2: begin
                if (s_q.cfg.three) begin
                    if (s_q.cfg.waits != '0) begin
                        s_d.st   = ST_TW;
                        s_d.wcnt = s_q.cfg.waits;
                    end else begin
                        s_d.st = ST_T3;
                    end
                end else begin
                    last_state = 1'b1;
                end
            end
            ST_TW: begin
                if (s_q.wcnt == WAIT_W'(1)) s_d.st = ST_T3;
                else                        s_d.wcnt = s_q.wcnt - WAIT_W'(1);
            end
            ST_T3:   last_state = 1'b1;
            default: s_d.st = ST_IDLE;
        endcase

        if (last_state) begin
            if (!s_q.we) begin
                if (s_q.cfg.wide) begin
                    s_d.rdata = {s_q.be[1] ? din_hi : BYTE_W'(0),
                                 s_q.be[0] ? din_lo : BYTE_W'(0)};
                end else if (cur_lo) begin
                    s_d.rdata[BYTE_W-1:0] = din_hi;
                end else begin
                    s_d.rdata[DATA_W-1:BYTE_W] = din_hi;
                end
            end
            if (s_q.split && !s_q.half) begin
                s_d.half = 1'b1;
                s_d.st   = ST_T1;
            end else begin
                s_d.st         = ST_IDLE;
                s_d.ready      = 1'b1;
                s_d.prev_valid = 1'b1;
                s_d.prev_read  = !s_q.we;
                s_d.prev_area  = s_q.area;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o    = s_q.ready;
    assign rdata_o    = s_q.rdata;
    assign ext_addr_o = {s_q.waddr, cur_lo};
    assign ext_dout_o = s_q.cfg.wide ? s_q.wdata :
                        {(cur_lo ? s_q.wdata[BYTE_W-1:0] : s_q.wdata[DATA_W-1:BYTE_W]),
                         BYTE_W'(0)};
    assign ext_doe_o  = active && s_q.we;
    assign rd_n_o     = !(active && !s_q.we);
    assign wrh_n_o    = !(wr_phase && (!s_q.cfg.wide || s_q.be[1]));
    assign wrl_n_o    = !(wr_phase && s_q.cfg.wide && s_q.be[0]);
    assign active_o   = active;
    assign area_o     = s_q.area;

    // R3: completion is a single-cycle pulse
    a_r3_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ready |=> !s_q.ready);

    // R4: wait states occur only on three-state areas
    a_r4_wait_three_only: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_TW) |-> s_q.cfg.three);

    // R5: no write strobe in the first bus state
    a_r5_no_wr_first: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_T1) |-> (wrh_n_o && wrl_n_o));

    // R7: narrow areas never use the lower write strobe
    a_r7_narrow_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cfg.wide |-> wrl_n_o);

    // R8: a split request completes only after its second half
    a_r8_split_second: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ready && s_q.split) |-> s_q.half);

    // R9 / R10: the idle cycle drives nothing
    a_r9_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_GAP) |-> (rd_n_o && wrh_n_o && wrl_n_o && !ext_doe_o));

    // R12: captured setting holds for the whole cycle
    a_r12_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE) |=> ((s_q.st == ST_IDLE) || $stable(s_q.cfg)));

endmodule

// File: rtl/ext_bus_if.sv
module ext_bus_if
    import ebi_pkg::*;
#(
    parameter  int ADDR_W  = 24,
    parameter  int DATA_W  = 16,
    parameter  int N_AREAS = 8,
    parameter  int SEL_W   = 4,
    localparam int AREA_W  = $clog2(N_AREAS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               req,
    input  logic               req_we,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [1:0]         req_be,
    output logic               ready,
    output logic [DATA_W-1:0]  rdata,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_doe,
    input  logic [DATA_W-1:0]  ext_din,
    output logic               ext_rd_n,
    output logic               ext_wrh_n,
    output logic               ext_wrl_n,
    output logic [N_AREAS-1:0] ext_cs_n
);

    area_cfg_t         area_cfg [N_AREAS];
    logic              idle_rr_en, idle_rw_en;
    logic              bus_active;
    logic [AREA_W-1:0] cur_area;

    ebi_cfg_bank #(.N_AREAS(N_AREAS), .SEL_W(SEL_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .area_cfg_o   (area_cfg),
        .idle_rr_en_o (idle_rr_en),
        .idle_rw_en_o (idle_rw_en)
    );

    ebi_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_AREAS(N_AREAS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .we_i         (req_we),
        .addr_i       (req_addr),
        .wdata_i      (req_wdata),
        .be_i         (req_be),
        .req_area_i   (req_addr[ADDR_W-1 -: AREA_W]),
        .area_cfg_i   (area_cfg),
        .idle_rr_en_i (idle_rr_en),
        .idle_rw_en_i (idle_rw_en),
        .ext_din_i    (ext_din),
        .ready_o      (ready),
        .rdata_o      (rdata),
        .ext_addr_o   (ext_addr),
        .ext_dout_o   (ext_dout),
        .ext_doe_o    (ext_doe),
        .rd_n_o       (ext_rd_n),
        .wrh_n_o      (ext_wrh_n),
        .wrl_n_o      (ext_wrl_n),
        .active_o     (bus_active),
        .area_o       (cur_area)
    );

    ebi_area_decode #(.N_AREAS(N_AREAS)) u_dec (
        .area_i   (cur_area),
        .active_i (bus_active),
        .cs_n_o   (ext_cs_n)
    );

    // R1: at most one chip select low
    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    // R1: a chip select is low exactly when a read strobe or write drive is active
    a_r1_cs_with_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cs_n != '1) == (!ext_rd_n || ext_doe));

    // R5: read and write strobes are never low together
    a_r5_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |-> (ext_wrh_n && ext_wrl_n));

endmodule

// File: tb/sim_ext_bus_if.sv
module sim_ext_bus_if;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [3:0]  cfg_wdata = '0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        ready;
    logic [15:0] rdata;
    logic [23:0] ext_addr;
    logic [15:0] ext_dout;
    logic        ext_doe;
    logic [15:0] ext_din;
    logic        ext_rd_n, ext_wrh_n, ext_wrl_n;
    logic [7:0]  ext_cs_n;

    int n_chk = 0;
    int n_err = 0;

    // Shadow of the settings, as defined by the requirements
    logic [1:0] sh_wait [8];
    logic       sh_three [8];
    logic       sh_wide [8];
    logic       en_rr = 1'b1, en_rw = 1'b1;
    logic       prv_valid = 1'b0, prv_read = 1'b0;
    logic [2:0] prv_area = '0;

    // Bus monitor
    bit         mon_on = 1'b0;
    logic [2:0] mon_area = '0;
    int         cs_cnt, cs_bad, rd_cnt, hi_cnt, lo_cnt;
    logic [23:0] hi_first_addr, hi_last_addr, lo_addr;
    logic [7:0]  hi_first_data, hi_last_data, lo_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ext_din = {ext_addr[7:0] ^ 8'hA5, ext_addr[7:0] ^ 8'h3C};

    ext_bus_if u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .ready(ready), .rdata(rdata),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
        .ext_din(ext_din), .ext_rd_n(ext_rd_n),
        .ext_wrh_n(ext_wrh_n), .ext_wrl_n(ext_wrl_n), .ext_cs_n(ext_cs_n)
    );

    always @(negedge clk) begin
        if (mon_on) begin
            if (ext_cs_n != 8'hFF) begin
                cs_cnt++;
                if (ext_cs_n != ~(8'b1 << mon_area)) cs_bad++;
            end
            if (!ext_rd_n) rd_cnt++;
            if (!ext_wrh_n) begin
                if (hi_cnt == 0) begin
                    hi_first_addr = ext_addr;
                    hi_first_data = ext_dout[15:8];
                end
                hi_last_addr = ext_addr;
                hi_last_data = ext_dout[15:8];
                hi_cnt++;
            end
            if (!ext_wrl_n) begin
                lo_addr = ext_addr;
                lo_data = ext_dout[7:0];
                lo_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] sel, input logic [3:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 4'd8) begin
            sh_wait[sel[2:0]]  = val[3:2];
            sh_three[sel[2:0]] = val[1];
            sh_wide[sel[2:0]]  = val[0];
        end else if (sel == 4'd8) begin
            en_rr = val[0];
            en_rw = val[1];
        end
    endtask

    task automatic txn(input logic [2:0] area, input logic we, input logic [20:0] off,
                       input logic [15:0] wd, input logic [1:0] be, input string tag);
        int n, halves, lat, cnt, idle, raw;
        string lt, dt;
        logic [7:0] eb, ob, ab;
        logic [23:0] ea, oa;
        logic [15:0] exp_rd;
        n      = sh_three[area] ? 3 + int'(sh_wait[area]) : 2;
        halves = (!sh_wide[area] && be == 2'b11) ? 2 : 1;
        raw    = (prv_valid && prv_read && ((!we && area != prv_area) || we)) ? 1 : 0;
        idle   = (prv_valid && prv_read &&
                  ((!we && en_rr && area != prv_area) || (we && en_rw))) ? 1 : 0;
        lat    = 1 + idle + halves * n;
        if (tag == "R12" || tag == "R2") lt = tag;
        else if (idle == 1) lt = we ? "R10" : "R9";
        else if (raw == 1) lt = "R11";
        else if (halves == 2) lt = "R8";
        else if (!sh_three[area] && sh_wait[area] != 0) lt = "R4";
        else lt = "R3";
        dt = sh_wide[area] ? "R6" : (halves == 2 ? "R8" : "R7");

        @(negedge clk);
        cs_cnt = 0; cs_bad = 0; rd_cnt = 0; hi_cnt = 0; lo_cnt = 0;
        mon_area = area; mon_on = 1'b1;
        req = 1'b1; req_we = we; req_addr = {area, off}; req_wdata = wd; req_be = be;
        cnt = 0;
        while (cnt < 100) begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
            if (ready) break;
        end
        req = 1'b0;
        mon_on = 1'b0;

        chk({lt, " latency"}, 32'(cnt), 32'(lat));
        chk("R1 chip-select cycles", 32'(cs_cnt), 32'(halves * n));
        chk("R1 wrong chip select", 32'(cs_bad), 32'd0);

        ea = {area, off[20:1], 1'b0};
        oa = {area, off[20:1], 1'b1};
        eb = ea[7:0];
        ob = oa[7:0];
        if (!we) begin
            chk("R5 read strobe states", 32'(rd_cnt), 32'(halves * n));
            if (sh_wide[area]) begin
                ab = be[1] ? eb : ob;
                exp_rd = {be[1] ? (ab ^ 8'hA5) : 8'h00, be[0] ? (ab ^ 8'h3C) : 8'h00};
            end else if (halves == 2) begin
                exp_rd = {eb ^ 8'hA5, ob ^ 8'hA5};
            end else if (be[1]) begin
                exp_rd = {eb ^ 8'hA5, 8'h00};
            end else begin
                exp_rd = {8'h00, ob ^ 8'hA5};
            end
            chk({dt, " R13 read data"}, 32'(rdata), 32'(exp_rd));
        end else begin
            chk("R5 read strobe idle on write", 32'(rd_cnt), 32'd0);
            if (sh_wide[area]) begin
                chk("R5 upper strobe states", 32'(hi_cnt), be[1] ? 32'(n - 1) : 32'd0);
                chk("R5 lower strobe states", 32'(lo_cnt), be[0] ? 32'(n - 1) : 32'd0);
                if (be[1]) begin
                    chk({dt, " upper addr"}, 32'(hi_first_addr), 32'(ea));
                    chk({dt, " upper data"}, 32'(hi_first_data), 32'(wd[15:8]));
                end
                if (be[0]) begin
                    chk({dt, " lower addr"}, 32'(lo_addr), be[1] ? 32'(ea) : 32'(oa));
                    chk({dt, " lower data"}, 32'(lo_data), 32'(wd[7:0]));
                end
            end else begin
                chk("R7 lower strobe unused", 32'(lo_cnt), 32'd0);
                chk("R5 narrow strobe states", 32'(hi_cnt), 32'(halves * (n - 1)));
                if (halves == 2) begin
                    chk("R8 first addr", 32'(hi_first_addr), 32'(ea));
                    chk("R8 first data", 32'(hi_first_data), 32'(wd[15:8]));
                    chk("R8 second addr", 32'(hi_last_addr), 32'(oa));
                    chk("R8 second data", 32'(hi_last_data), 32'(wd[7:0]));
                end else begin
                    chk("R7 byte addr", 32'(hi_first_addr), be[1] ? 32'(ea) : 32'(oa));
                    chk("R7 byte data", 32'(hi_first_data),
                        be[1] ? 32'(wd[15:8]) : 32'(wd[7:0]));
                end
            end
        end
        prv_valid = 1'b1;
        prv_read  = !we;
        prv_area  = area;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            sh_wait[i] = 2'd3; sh_three[i] = 1'b1; sh_wide[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13 cs after reset", 32'(ext_cs_n), 32'hFF);
        chk("R13 strobes after reset", 32'({ext_rd_n, ext_wrh_n, ext_wrl_n}), 32'h7);
        chk("R13 ready/doe after reset", 32'({ready, ext_doe}), 32'h0);
        rst_n = 1'b1;

        // R2: reset defaults in use
        txn(3'd5, 1'b0, 21'h01234, 16'h0, 2'b11, "R2");

        // Sweep every width / timing / wait combination
        for (int c = 0; c < 16; c++) begin
            logic [2:0] a, b;
            logic [20:0] off;
            logic [15:0] wd;
            a   = 3'(c);
            b   = 3'(c + 3);
            off = 21'(c * 4663 + 6);
            wd  = 16'(c * 517 + 16'h1234);
            cfg_write({1'b0, a}, 4'(c));
            txn(a, 1'b1, off, wd, 2'b11, "sweep");
            txn(a, 1'b0, off, 16'h0, 2'b11, "sweep");
            txn(a, 1'b0, off + 21'd64, 16'h0, 2'b11, "sweep");
            txn(b, 1'b0, off + 21'd130, 16'h0, 2'b11, "sweep");
        end

        // Single-byte lanes on a wide and a narrow area
        cfg_write(4'd1, 4'b0001);
        cfg_write(4'd2, 4'b0000);
        for (int k = 0; k < 2; k++) begin
            logic [1:0] be;
            be = (k == 0) ? 2'b01 : 2'b10;
            txn(3'd1, 1'b1, 21'h00A0, 16'hC35A, be, "lane");
            txn(3'd1, 1'b0, 21'h00A0, 16'h0, be, "lane");
            txn(3'd2, 1'b1, 21'h0152, 16'h9D71, be, "lane");
            txn(3'd2, 1'b0, 21'h0152, 16'h0, be, "lane");
        end

        // Idle-cycle enables
        cfg_write(4'd8, 4'b0010);
        txn(3'd1, 1'b0, 21'h10, 16'h0, 2'b11, "idle");
        txn(3'd2, 1'b0, 21'h20, 16'h0, 2'b11, "idle");
        txn(3'd2, 1'b1, 21'h20, 16'h55AA, 2'b11, "idle");
        cfg_write(4'd8, 4'b0000);
        txn(3'd2, 1'b0, 21'h30, 16'h0, 2'b11, "idle");
        txn(3'd2, 1'b1, 21'h30, 16'hAA55, 2'b11, "idle");
        cfg_write(4'd8, 4'b0001);
        txn(3'd1, 1'b0, 21'h40, 16'h0, 2'b11, "idle");
        txn(3'd2, 1'b0, 21'h50, 16'h0, 2'b11, "idle");
        txn(3'd2, 1'b1, 21'h50, 16'h1111, 2'b11, "idle");
        txn(3'd1, 1'b1, 21'h60, 16'h2222, 2'b11, "idle");

        // R2: selects above the idle register change nothing
        for (int s = 9; s < 16; s++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_sel = 4'(s); cfg_wdata = 4'b0000;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        txn(3'd0, 1'b0, 21'h77, 16'h0, 2'b11, "R2");
        txn(3'd2, 1'b0, 21'h78, 16'h0, 2'b11, "R2");

        // R12: a mid-cycle setting change only affects the next request
        cfg_write(4'd4, 4'b1111);
        fork
            txn(3'd4, 1'b0, 21'h0400, 16'h0, 2'b11, "R12");
            begin
                repeat (3) @(negedge clk);
                cfg_write(4'd4, 4'b0001);
            end
        join
        txn(3'd4, 1'b0, 21'h0402, 16'h0, 2'b11, "R12");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule